// File: doc/BRIEF.md
# Commit-Time Trap In-Lining Controller

This controller takes over when the instruction at the commit head carries a pending exception that software must service. It looks up the instruction count of that cause's first-level handler. It compares that count with the free reorder-buffer entries and, when the core has them, the free reservation stations. If both have room, it sends fetch to the handler entry without discarding anything. The user instructions already in flight stay in place, and those that do not depend on the faulting instruction keep executing alongside the privileged handler. If either resource is short, it orders a full pipeline flush and then sends fetch to the same entry.

On both paths it saves a resume address. Restartable causes, such as a translation miss, save the faulting instruction's own PC so that the instruction runs again. Causes that resume after the faulting instruction, such as device interrupts, save the address one instruction further on. When the handler's return instruction retires, the controller sends fetch back to the saved address and drops the privilege mode.

The exception head is a valid/ready channel. The core holds `exc_valid` and the head fields steady until it sees `exc_ready` high in the same cycle. `exc_ready` is high only while the controller is idle, so a head that is offered while a handler is in progress waits and is not lost. The resource counts are captured in the accept cycle.

Top module: `inline_trap_ctl`

## Requirements
- R1: `exc_ready` is high after reset and whenever no exception is in progress. It goes low on the cycle after an exception is accepted. Exceptions offered while it is low are ignored and do not change the saved PC.
- R2: When the captured `rob_free` and `rs_free` are both at least the cause's handler length, the cycle two clocks after acceptance shows `redir_valid`=1, `flush`=0, `inline_active`=1 and `priv_mode`=1.
- R3: When the captured `rob_free` is below the handler length, that cycle shows `flush`=1, `redir_valid`=1, `inline_active`=0 and `priv_mode`=1.
- R4: With `USE_RS`=1, a captured `rs_free` below the handler length also selects the flush path, even when `rob_free` is large enough.
- R5: Handler length is a per-cause parameter, with cause i in bits [i*CNT_W +: CNT_W] of `HANDLER_LENS`. The redirect target on entry is `HANDLER_BASE + cause*HANDLER_STRIDE`.
- R6: For a cause whose bit in `RESTART_MASK` is 1, the saved PC is the faulting `exc_pc`.
- R7: For a cause whose bit in `RESTART_MASK` is 0, the saved PC is `exc_pc + INSTR_BYTES`.
- R8: A `rfi_valid` while a handler is running gives, on the next cycle, a one-cycle `redir_valid` with `redir_pc` equal to the saved PC, together with `priv_mode`=0 and `inline_active`=0. `exc_ready` returns high one cycle later.
- R9: A `rfi_valid` while no handler is running is ignored: no redirect follows.
- R10: During reset `flush`, `redir_valid`, `priv_mode` and `inline_active` are 0.
- R11: `flush` and `redir_valid` are one-cycle pulses, and `flush` is never high together with `inline_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Commit head holds an exception for software |
| exc_ready | output | 1 | Controller idle; exception accepted when both are high |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_pc | input | PC_W | PC of the faulting instruction |
| rob_free | input | CNT_W | Free reorder-buffer entries |
| rs_free | input | CNT_W | Free reservation stations |
| rfi_valid | input | 1 | Handler's return instruction retired |
| flush | output | 1 | Discard all in-flight instructions (pulse) |
| redir_valid | output | 1 | Fetch redirect strobe (pulse) |
| redir_pc | output | PC_W | Redirect target, meaningful with `redir_valid` |
| priv_mode | output | 1 | Newly fetched instructions are privileged |
| inline_active | output | 1 | Handler is running in-line next to user code |

## Verification
A wrong path decision shows up two cycles after acceptance as a `flush` pulse in the wrong state next to `inline_active`. That is the same cycle the redirect target can be checked. A corrupted saved PC stays hidden through the whole handler and appears only in the redirect that follows a return. For that reason every sweep point runs a full round trip, and a stray exception is offered mid-handler to catch overwrites. A stuck state shows up as `exc_ready` failing to rise one cycle after that return redirect.

// File: rtl/inline_trap_pkg.sv
package inline_trap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_INLINE,
    ST_FLUSH,
    ST_RETURN
  } trap_state_e;
endpackage

// File: rtl/trap_fit_check.sv
module trap_fit_check #(
  parameter int NUM_CAUSE = 4,
  parameter int CAUSE_W   = 2,
  parameter int CNT_W     = 6,
  parameter logic [NUM_CAUSE*CNT_W-1:0] HANDLER_LENS = {NUM_CAUSE{6'd10}},
  parameter bit USE_RS    = 1'b1
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CNT_W-1:0]   rob_free_i,
  input  logic [CNT_W-1:0]   rs_free_i,
  output logic               fit_o
);
  logic [CNT_W-1:0] len_tab [NUM_CAUSE];
  logic [CNT_W-1:0] need;
  logic             rob_ok, rs_ok;

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_len
    assign len_tab[i] = HANDLER_LENS[i*CNT_W +: CNT_W];
  end

  assign need   = len_tab[cause_i];
  assign rob_ok = rob_free_i >= need;
  // without reservation stations only the reorder buffer gates the choice
  assign rs_ok  = (USE_RS == 1'b0) || (rs_free_i >= need);
  assign fit_o  = rob_ok && rs_ok;
endmodule

// File: rtl/trap_epc_store.sv
module trap_epc_store #(
  parameter int NUM_CAUSE   = 4,
  parameter int CAUSE_W     = 2,
  parameter int PC_W        = 16,
  parameter int INSTR_BYTES = 4,
  parameter logic [NUM_CAUSE-1:0] RESTART_MASK = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic [PC_W-1:0]    epc_o
);
  logic restart;
  assign restart = RESTART_MASK[cause_i];

  always_ff @(posedge clk) begin
    if (!rst_n) epc_o <= '0;
    else if (cap_i) epc_o <= restart ? pc_i : pc_i + PC_W'(INSTR_BYTES);
  end

  // R6
  restart_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && restart) |=> (epc_o == $past(pc_i)));
  // R7
  resume_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !restart) |=> (epc_o != $past(pc_i)));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import inline_trap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_valid_i,
  input  logic fit_i,
  input  logic rfi_i,
  output logic exc_ready_o,
  output logic accept_o,
  output logic deciding_o,
  output logic flush_o,
  output logic redir_valid_o,
  output logic sel_ret_o,
  output logic priv_o,
  output logic inline_o
);
  trap_state_e st;
  logic in_handler;

  assign exc_ready_o = (st == ST_IDLE);
  assign accept_o    = exc_valid_i && exc_ready_o;
  assign deciding_o  = (st == ST_DECIDE);
  assign in_handler  = (st == ST_INLINE) || (st == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      flush_o       <= 1'b0;
      redir_valid_o <= 1'b0;
      sel_ret_o     <= 1'b0;
      priv_o        <= 1'b0;
      inline_o      <= 1'b0;
    end else begin
      flush_o       <= 1'b0;
      redir_valid_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (exc_valid_i) st <= ST_DECIDE;
        ST_DECIDE: begin
          redir_valid_o <= 1'b1;
          sel_ret_o     <= 1'b0;
          priv_o        <= 1'b1;
          if (fit_i) begin
            inline_o <= 1'b1;
            st       <= ST_INLINE;
          end else begin
            flush_o  <= 1'b1;
            st       <= ST_FLUSH;
          end
        end
        ST_INLINE, ST_FLUSH: if (rfi_i) begin
          redir_valid_o <= 1'b1;
          sel_ret_o     <= 1'b1;
          priv_o        <= 1'b0;
          inline_o      <= 1'b0;
          st            <= ST_RETURN;
        end
        ST_RETURN: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !exc_ready_o);
  // R11
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  // R11
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !inline_o);
  // R8
  rfi_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_i && in_handler) |=> (redir_valid_o && !priv_o && !inline_o));
  // R9
  stray_rfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_i && exc_ready_o) |=> !redir_valid_o);
endmodule

// File: rtl/inline_trap_ctl.sv
module inline_trap_ctl #(
  parameter int NUM_CAUSE   = 4,
  parameter int PC_W        = 16,
  parameter int CNT_W       = 6,
  parameter int INSTR_BYTES = 4,
  parameter bit USE_RS      = 1'b1,
  parameter logic [NUM_CAUSE*CNT_W-1:0] HANDLER_LENS = {NUM_CAUSE{6'd10}},
  parameter logic [NUM_CAUSE-1:0]       RESTART_MASK = 4'b0011,
  parameter logic [PC_W-1:0]            HANDLER_BASE   = 16'h0100,
  parameter logic [PC_W-1:0]            HANDLER_STRIDE = 16'h0040,
  localparam int CAUSE_W = (NUM_CAUSE > 1) ? $clog2(NUM_CAUSE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  output logic               exc_ready,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [PC_W-1:0]    exc_pc,
  input  logic [CNT_W-1:0]   rob_free,
  input  logic [CNT_W-1:0]   rs_free,
  input  logic               rfi_valid,
  output logic               flush,
  output logic               redir_valid,
  output logic [PC_W-1:0]    redir_pc,
  output logic               priv_mode,
  output logic               inline_active
);
  logic [CAUSE_W-1:0] cause_q;
  logic [CNT_W-1:0]   rob_q, rs_q;
  logic [PC_W-1:0]    epc, entry;
  logic accept, deciding, fit, sel_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      rob_q   <= '0;
      rs_q    <= '0;
    end else if (accept) begin
      cause_q <= exc_cause;
      rob_q   <= rob_free;
      rs_q    <= rs_free;
    end
  end

  trap_fit_check #(
    .NUM_CAUSE(NUM_CAUSE), .CAUSE_W(CAUSE_W), .CNT_W(CNT_W),
    .HANDLER_LENS(HANDLER_LENS), .USE_RS(USE_RS)
  ) u_fit (
    .cause_i(cause_q), .rob_free_i(rob_q), .rs_free_i(rs_q), .fit_o(fit)
  );

  trap_epc_store #(
    .NUM_CAUSE(NUM_CAUSE), .CAUSE_W(CAUSE_W), .PC_W(PC_W),
    .INSTR_BYTES(INSTR_BYTES), .RESTART_MASK(RESTART_MASK)
  ) u_epc (
    .clk(clk), .rst_n(rst_n), .cap_i(accept), .cause_i(exc_cause),
    .pc_i(exc_pc), .epc_o(epc)
  );

  trap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid), .fit_i(fit),
    .rfi_i(rfi_valid), .exc_ready_o(exc_ready), .accept_o(accept),
    .deciding_o(deciding), .flush_o(flush), .redir_valid_o(redir_valid),
    .sel_ret_o(sel_ret), .priv_o(priv_mode), .inline_o(inline_active)
  );

  assign entry    = HANDLER_BASE + PC_W'(cause_q) * HANDLER_STRIDE;
  assign redir_pc = sel_ret ? epc : entry;

  // R2
  inline_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deciding && fit) |=> (!flush && inline_active && priv_mode && redir_valid));
  // R3
  flush_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deciding && !fit) |=> (flush && !inline_active && priv_mode && redir_valid));
endmodule

// File: tb/sim_inline_trap_ctl.sv
`timescale 1ns/1ps
module sim_inline_trap_ctl;
  localparam int NC = 4;
  localparam logic [23:0] LENS = {6'd9, 6'd6, 6'd12, 6'd10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 1'b0, rfi_valid = 1'b0;
  logic [1:0] exc_cause = '0;
  logic [15:0] exc_pc = '0;
  logic [5:0] rob_free = '0, rs_free = '0;
  logic exc_ready, flush, redir_valid, priv_mode, inline_active;
  logic [15:0] redir_pc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  inline_trap_ctl #(.NUM_CAUSE(NC), .HANDLER_LENS(LENS)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
    .exc_cause(exc_cause), .exc_pc(exc_pc), .rob_free(rob_free),
    .rs_free(rs_free), .rfi_valid(rfi_valid), .flush(flush),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .priv_mode(priv_mode),
    .inline_active(inline_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input int c);
    return int'(LENS[c*6 +: 6]);
  endfunction

  task automatic round_trip(input int c, input int rob, input int rs, input logic [15:0] pc);
    logic fit;
    logic [15:0] entry, epc;
    fit   = (rob >= len_of(c)) && (rs >= len_of(c));
    entry = 16'h0100 + 16'(c) * 16'h0040;
    epc   = (c < 2) ? pc : pc + 16'd4;
    @(negedge clk);
    chk("R1 ready idle", exc_ready, 1);
    exc_valid = 1'b1; exc_cause = 2'(c); exc_pc = pc;
    rob_free = 6'(rob); rs_free = 6'(rs);
    @(negedge clk);
    chk("R1 ready low", exc_ready, 0);
    exc_cause = 2'd3; exc_pc = 16'hBEEF; rob_free = 6'd63; rs_free = 6'd63;
    @(negedge clk);
    chk("R1 busy", exc_ready, 0);
    chk("R5 entry", redir_pc, entry);
    chk("R2 R3 R4 redirect", redir_valid, 1);
    chk("R3 R4 flush", flush, !fit);
    chk("R2 inline", inline_active, fit);
    chk("R2 priv", priv_mode, 1);
    @(negedge clk);
    chk("R11 flush pulse", flush, 0);
    chk("R11 redirect pulse", redir_valid, 0);
    chk("R2 priv held", priv_mode, 1);
    exc_valid = 1'b0; rfi_valid = 1'b1;
    @(negedge clk);
    rfi_valid = 1'b0;
    chk("R8 return strobe", redir_valid, 1);
    chk("R6 R7 saved pc", redir_pc, epc);
    chk("R8 priv off", priv_mode, 0);
    chk("R8 inline off", inline_active, 0);
    @(negedge clk);
    chk("R8 strobe ends", redir_valid, 0);
    chk("R8 ready again", exc_ready, 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 flush", flush, 0);
    chk("R10 redirect", redir_valid, 0);
    chk("R10 priv", priv_mode, 0);
    chk("R10 inline", inline_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready", exc_ready, 1);
    // R9 stray return while idle
    rfi_valid = 1'b1;
    @(negedge clk);
    rfi_valid = 1'b0;
    chk("R9 no redirect", redir_valid, 0);
    chk("R9 priv", priv_mode, 0);
    // R2 R3 R4 R5 R6 R7 sweep: every cause, every count pair 0..15
    for (int c = 0; c < NC; c++)
      for (int rob = 0; rob < 16; rob++)
        for (int rs = 0; rs < 16; rs++)
          round_trip(c, rob, rs, 16'h2000 + 16'(c*1024 + rob*64 + rs*4));
    // R4 large reorder buffer space with stations short
    round_trip(1, 63, 11, 16'h7000);
    round_trip(1, 63, 12, 16'h7004);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule